// File: doc/BRIEF.md
# Trace Buffer Fill Counter

This block keeps track of how much of a circular trace store holds valid capture data during a debug session. The store has 64 lines, and each line is 64 bits wide. The block counts in 32-bit half-line units. A full-line store strobe adds two units and a half-line store strobe adds one. The upper six bits of the count act as the line write pointer, so a 64-line storage array can be addressed from the block directly.

When the count wraps past its top value, a sticky full flag is set and all 64 lines are treated as valid. What happens after the wrap depends on the trigger alignment mode:

- In end or mid alignment, capture carries on and overwrites the oldest entries.
- In begin alignment, the wrap ends the session. The block raises a one-cycle request to clear the arm control bit and stops counting.

A write of 1 to the arm bit starts a fresh session and zeroes the count and the flag. Only a power-on reset clears the count and the flag. A system reset only ends the running session, so the number of entries captured before that reset can still be read afterwards. The block has no read path, so reading the trace store never changes the count.

Top module: `trc_fill_counter`

## Requirements
- R1: While armed, a full-line strobe adds 2 to the 7-bit count, modulo 128, on the next clock edge.
- R2: While armed, a half-line strobe on its own adds 1 to the count, modulo 128.
- R3: When the half-line and full-line strobes are both high in one cycle, only the full-line increment of 2 is applied.
- R4: When the session is not armed, both strobes are ignored and the count does not change.
- R5: An arm write pulse clears the count and the full flag and arms the session. It takes precedence over any strobe in the same cycle.
- R6: A store that carries the count past 127 sets the full flag. The flag stays set until an arm write or a power-on reset.
- R7: With alignment 2'b00 (end), 2'b01 (mid) or 2'b11 (treated as end), counting continues after the wrap, starting from the wrapped count value.
- R8: With alignment 2'b10 (begin), a wrapping store disarms the session. In the following cycle arm_clr_o is high for exactly one cycle, and later strobes are ignored.
- R9: Power-on reset (por_n low, asynchronous) clears the count, the full flag, the armed state and arm_clr_o.
- R10: System reset (sys_rst_n low) disarms the session and clears arm_clr_o. It leaves the count and the full flag unchanged.
- R11: wr_line_o always equals count bits [6:1], the index of the line currently being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; ends the session only |
| arm_wr_i | input | 1 | Pulse: arm control bit written to 1 |
| align_i | input | 2 | Trigger alignment: 00 end, 01 mid, 10 begin, 11 end |
| half_wr_i | input | 1 | 32-bit half-line store strobe |
| full_wr_i | input | 1 | 64-bit full-line store strobe |
| count_o | output | 7 | Valid data in half-line units |
| full_o | output | 1 | Sticky flag: the count has wrapped |
| wr_line_o | output | 6 | Current line write index |
| arm_clr_o | output | 1 | One-cycle request to clear the arm bit |

## Verification
The bench checks the following corner cases:

- **Top of the count.** It drives the count to 126 and 127 and then pushes it across the top. A design with an off-by-one carry would set the full flag one store early or late, or would skip the wrapped value.
- **Alignment modes.** Each mode goes through the wrap. A design that always stopped would freeze mid-mode capture. A design that never stopped would keep counting and never raise the clear request in begin mode.
- **Reset split.** It checks that a system reset keeps the count and the flag, and that a power-on reset clears them. A design with the two resets merged would lose the count captured before the reset.
- **Same-cycle collisions.** It drives a half-line strobe together with a full-line strobe, and an arm write together with a strobe. Wrong priority would show up as an increment of 3 or 1, or as a count that is non-zero right after arming.

// File: rtl/trc_fill_pkg.sv
package trc_fill_pkg;

  typedef enum logic [1:0] {
    ALIGN_END   = 2'b00,
    ALIGN_MID   = 2'b01,
    ALIGN_BEGIN = 2'b10,
    ALIGN_RSVD  = 2'b11
  } align_e;

  // Half-line units contributed by one cycle of strobes; full-line wins.
  function automatic logic [1:0] store_units(input logic half, input logic full);
    if (full)      return 2'd2;
    else if (half) return 2'd1;
    else           return 2'd0;
  endfunction

  // Alignment modes in which a wrap terminates the session.
  function automatic logic wrap_stops(input logic [1:0] align);
    return align == ALIGN_BEGIN;
  endfunction

endpackage

// File: rtl/trc_fill_step.sv
module trc_fill_step
  import trc_fill_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic             half_i,
  input  logic             full_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic             adv_o,
  output logic             wrap_o
);

  logic [CNT_W:0] sum;

  always_comb begin
    sum    = {1'b0, cnt_i} + {{(CNT_W-1){1'b0}}, store_units(half_i, full_i)};
    adv_o  = en_i & (half_i | full_i);
    wrap_o = adv_o & sum[CNT_W];
    nxt_o  = sum[CNT_W-1:0];
  end

endmodule

// File: rtl/trc_fill_status.sv
module trc_fill_status #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);

  // Only power-on reset reaches this state; system reset preserves it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_o  <= '0;
      full_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o  <= '0;
      full_o <= 1'b0;
    end else if (adv_i) begin
      cnt_o <= nxt_i;
      if (wrap_i) full_o <= 1'b1;
    end
  end

endmodule

// File: rtl/trc_fill_session.sv
module trc_fill_session
  import trc_fill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_wr_i,
  input  logic       wrap_i,
  input  logic [1:0] align_i,
  output logic       stop_o,
  output logic       armed_o,
  output logic       arm_clr_o
);

  assign stop_o = wrap_i & wrap_stops(align_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o   <= 1'b0;
      arm_clr_o <= 1'b0;
    end else if (arm_wr_i) begin
      armed_o   <= 1'b1;
      arm_clr_o <= 1'b0;
    end else if (stop_o) begin
      armed_o   <= 1'b0;
      arm_clr_o <= 1'b1;
    end else begin
      arm_clr_o <= 1'b0;
    end
  end

endmodule

// File: rtl/trc_fill_counter.sv
module trc_fill_counter #(
  parameter int CNT_W = 7,
  localparam int LINE_W = CNT_W - 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              arm_wr_i,
  input  logic [1:0]        align_i,
  input  logic              half_wr_i,
  input  logic              full_wr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic [LINE_W-1:0] wr_line_o,
  output logic              arm_clr_o
);

  // Named internal events, visible to the bound checker.
  logic             armed;
  logic             step_en;
  logic             adv;
  logic             wrap;
  logic             stop_evt;
  logic             sess_rst_n;
  logic [CNT_W-1:0] cnt_nxt;

  assign sess_rst_n = por_n & sys_rst_n;
  assign step_en    = armed & ~arm_wr_i;

  trc_fill_step #(.CNT_W(CNT_W)) u_step (
    .cnt_i  (count_o),
    .en_i   (step_en),
    .half_i (half_wr_i),
    .full_i (full_wr_i),
    .nxt_o  (cnt_nxt),
    .adv_o  (adv),
    .wrap_o (wrap)
  );

  trc_fill_status #(.CNT_W(CNT_W)) u_status (
    .clk    (clk),
    .por_n  (por_n),
    .clr_i  (arm_wr_i),
    .adv_i  (adv),
    .wrap_i (wrap),
    .nxt_i  (cnt_nxt),
    .cnt_o  (count_o),
    .full_o (full_o)
  );

  trc_fill_session u_session (
    .clk       (clk),
    .rst_n     (sess_rst_n),
    .arm_wr_i  (arm_wr_i),
    .wrap_i    (wrap),
    .align_i   (align_i),
    .stop_o    (stop_evt),
    .armed_o   (armed),
    .arm_clr_o (arm_clr_o)
  );

  assign wr_line_o = count_o[CNT_W-1:1];

endmodule

// File: rtl/trc_fill_counter_chk.sv
module trc_fill_counter_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             arm_wr_i,
  input logic             full_wr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             full_o,
  input logic             arm_clr_o,
  input logic             armed,
  input logic             wrap,
  input logic             stop_evt
);

  assert_full_adds_two_R1: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (armed && full_wr_i && !arm_wr_i) |=> count_o == CNT_W'($past(count_o) + 2));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && !arm_wr_i) |=> $stable(count_o));

  assert_arm_clears_R5: assert property (@(posedge clk) disable iff (!por_n)
    arm_wr_i |=> (count_o == '0 && !full_o));

  assert_wrap_sets_full_R6: assert property (@(posedge clk) disable iff (!por_n)
    wrap |=> full_o);

  assert_full_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
    (full_o && !arm_wr_i) |=> full_o);

  assert_begin_stop_R8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    stop_evt |=> (arm_clr_o && !armed));

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    arm_clr_o |=> !arm_clr_o);

endmodule

bind trc_fill_counter trc_fill_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .sys_rst_n (sys_rst_n),
  .arm_wr_i  (arm_wr_i),
  .full_wr_i (full_wr_i),
  .count_o   (count_o),
  .full_o    (full_o),
  .arm_clr_o (arm_clr_o),
  .armed     (armed),
  .wrap      (wrap),
  .stop_evt  (stop_evt)
);

// File: tb/trc_fill_counter_tb.sv
module trc_fill_counter_tb;

  localparam int CLK_P = 10;
  localparam int NVEC  = 10;

  // Vector fields: {arm, half, full, align[1:0], exp_count[6:0], exp_full}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 2'b00, 7'd0, 1'b0},  // R5 arm
    {1'b0, 1'b1, 1'b0, 2'b00, 7'd1, 1'b0},  // R2 half
    {1'b0, 1'b0, 1'b1, 2'b00, 7'd3, 1'b0},  // R1 full
    {1'b0, 1'b1, 1'b1, 2'b01, 7'd5, 1'b0},  // R3 both
    {1'b0, 1'b0, 1'b0, 2'b01, 7'd5, 1'b0},  // idle
    {1'b0, 1'b1, 1'b0, 2'b10, 7'd6, 1'b0},  // R2
    {1'b1, 1'b0, 1'b0, 2'b10, 7'd0, 1'b0},  // R5 rearm
    {1'b0, 1'b0, 1'b1, 2'b00, 7'd2, 1'b0},  // R1
    {1'b0, 1'b1, 1'b0, 2'b00, 7'd3, 1'b0},  // R2
    {1'b1, 1'b0, 1'b1, 2'b00, 7'd0, 1'b0}   // R5 arm wins
  };

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_rst_n = 1'b1;
  logic       arm_wr_i = 1'b0;
  logic [1:0] align_i = 2'b00;
  logic       half_wr_i = 1'b0;
  logic       full_wr_i = 1'b0;
  logic [6:0] count_o;
  logic       full_o;
  logic [5:0] wr_line_o;
  logic       arm_clr_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  trc_fill_counter u_dut (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .arm_wr_i  (arm_wr_i),
    .align_i   (align_i),
    .half_wr_i (half_wr_i),
    .full_wr_i (full_wr_i),
    .count_o   (count_o),
    .full_o    (full_o),
    .wr_line_o (wr_line_o),
    .arm_clr_o (arm_clr_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock with the given strobes; inputs return low afterwards.
  task automatic cyc(input logic arm, input logic half, input logic full);
    arm_wr_i = arm; half_wr_i = half; full_wr_i = full;
    @(posedge clk); #1;
    arm_wr_i = 1'b0; half_wr_i = 1'b0; full_wr_i = 1'b0;
  endtask

  task automatic fulls(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    @(posedge clk); #1;
    check("R9 reset count", count_o, 0);
    check("R9 reset full", full_o, 0);
    check("R9 reset clr", arm_clr_o, 0);
    por_n = 1'b1;
    @(posedge clk); #1;

    // R4: strobes before arming are ignored
    cyc(1'b0, 1'b1, 1'b1);
    check("R4 unarmed", count_o, 0);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      align_i = VEC[v][9:8];
      cyc(VEC[v][12], VEC[v][11], VEC[v][10]);
      check($sformatf("R1/R2/R3/R5 vec%0d count", v), count_o, int'(VEC[v][7:1]));
      check($sformatf("R5/R6 vec%0d full", v), full_o, int'(VEC[v][0]));
      check($sformatf("R11 vec%0d line", v), wr_line_o, int'(VEC[v][7:2]));
    end

    // End alignment wrap: R6, R7, R11
    align_i = 2'b00;
    cyc(1'b1, 1'b0, 1'b0);
    fulls(63);
    check("R11 line at top", wr_line_o, 63);
    check("R6 not full at 126", full_o, 0);
    fulls(1);
    check("R6 wrap count", count_o, 0);
    check("R6 wrap full", full_o, 1);
    check("R7 no clr in end mode", arm_clr_o, 0);
    fulls(1);
    check("R7 continues", count_o, 2);
    check("R6 full sticky", full_o, 1);

    // R10: system reset keeps count, ends session
    sys_rst_n = 1'b0;
    @(posedge clk); #1;
    sys_rst_n = 1'b1;
    check("R10 count kept", count_o, 2);
    check("R10 full kept", full_o, 1);
    fulls(1);
    check("R10 disarmed", count_o, 2);

    // Begin alignment: R8
    align_i = 2'b10;
    cyc(1'b1, 1'b0, 1'b0);
    check("R5 arm clears full", full_o, 0);
    fulls(63);
    cyc(1'b0, 1'b1, 1'b0);
    check("R2 count 127", count_o, 127);
    cyc(1'b0, 1'b1, 1'b0);
    check("R8 wrap count", count_o, 0);
    check("R8 wrap full", full_o, 1);
    check("R8 clr high", arm_clr_o, 1);
    fulls(1);
    check("R8 clr single", arm_clr_o, 0);
    check("R8 stopped", count_o, 0);

    // Mid alignment half-line wrap: R7
    align_i = 2'b01;
    cyc(1'b1, 1'b0, 1'b0);
    fulls(63);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    check("R7 mid wrap count", count_o, 0);
    check("R7 mid wrap full", full_o, 1);
    check("R7 mid no clr", arm_clr_o, 0);
    cyc(1'b0, 1'b1, 1'b0);
    check("R7 mid continues", count_o, 1);

    // Reserved alignment behaves as end: R7
    align_i = 2'b11;
    cyc(1'b1, 1'b0, 1'b0);
    fulls(64);
    check("R7 rsvd no clr", arm_clr_o, 0);
    fulls(1);
    check("R7 rsvd continues", count_o, 2);

    // R9: power-on reset clears everything
    por_n = 1'b0;
    #1;
    check("R9 por count", count_o, 0);
    check("R9 por full", full_o, 0);
    @(posedge clk); #1;
    por_n = 1'b1;
    fulls(1);
    check("R9 por disarms", count_o, 0);

    report();
  end

endmodule